// File: doc/BRIEF.md
# Banked Window Address Translator

This block turns a 16-bit processor address into a 32-bit virtual address. A programmable window, bounded by a start address (inclusive) and an end address (exclusive), marks the part of the processor map that is banked. An address inside the window is relocated: its distance from the window start is added to the page number shifted left by a programmable amount, and a programmable virtual base is added to that sum. Any address outside the window passes through unchanged with zero extension.

The same block also locates two fixed on-chip regions from an 8-bit setup register. The low four bits of that register place a 64-byte peripheral register block on a 4 KiB boundary. The high four bits place a 256-byte internal RAM block on a 256-byte boundary inside the first 4 KiB. The setup register is loaded through a write strobe and comes out of reset holding 0x01. Each cycle the block reports whether the current address falls in the window, in the peripheral block or in the RAM block. When the peripheral block and the RAM block overlap, the peripheral block takes the address.

Top module: `bank_xlat`

## Requirements
- R1: `winHit` is 1 exactly when `winStart <= cpuAddr < winEnd` (unsigned). When `winEnd <= winStart` the window is empty.
- R2: When `winHit` is 1, `xlatAddr = (cpuAddr - winStart) + (pageReg << pageShift) + virtBase`, taken modulo 2^32. The shift is done at 32 bits.
- R3: When `winHit` is 0, `xlatAddr` is `cpuAddr` zero-extended to 32 bits.
- R4: After reset the setup register holds 0x01. This puts the peripheral block at 0x1000 and the RAM block at 0x0000.
- R5: A setup write (`initWrEn` = 1 at a rising clock edge) loads `initWrData`. Region decode uses the old value up to that edge and the new value from that edge on. Without a write, the value is kept.
- R6: `ioHit` is 1 exactly when `cpuAddr` lies in [B, B+64), where B = setup[3:0] * 0x1000.
- R7: `ramHit` is 1 exactly when `cpuAddr` lies in [M, M+256), where M = setup[7:4] * 0x100, and `ioHit` is 0.
- R8: `ioHit` and `ramHit` are never 1 together. In any overlap the peripheral block wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpuAddr | input | 16 | Processor address to translate |
| pageReg | input | 16 | Current page number |
| winStart | input | 16 | First address of the banked window |
| winEnd | input | 16 | First address past the banked window |
| pageShift | input | 5 | Left shift applied to the page number |
| virtBase | input | 32 | Virtual offset added inside the window |
| initWrEn | input | 1 | Setup register write strobe |
| initWrData | input | 8 | Setup register write data |
| xlatAddr | output | 32 | Translated virtual address |
| winHit | output | 1 | Address is inside the banked window |
| ioHit | output | 1 | Address is inside the peripheral register block |
| ramHit | output | 1 | Address is inside the internal RAM block |

## Verification
The interaction that matters most is a setup-register write arriving in the same cycle as a lookup that depends on it. For all 256 setup values, the bench holds the write strobe high while it probes the peripheral base of the old value and of the new value. It expects decode by the old value before the edge and by the new value after it. Window translation and region decode also land on the same address in the same cycle. The address sweeps therefore cover windows that overlap the peripheral and RAM blocks, an empty window, a one-byte window and a window whose sum wraps past 2^32. Every output is compared against arithmetic the bench computes itself.

// File: rtl/bank_xlat_pkg.sv
package bank_xlat_pkg;
  typedef struct packed {
    logic winHit;
    logic ioHit;
    logic ramHit;
  } xlatStrobes_t;
endpackage

// File: rtl/bank_region_match.sv
module bank_region_match #(
  parameter int ADDR_W = 16,
  parameter int SPAN   = 64
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  output logic              hit
);
  localparam int EXT_W = ADDR_W + 1;
  logic [EXT_W-1:0] limit;
  always_comb begin
    limit = {1'b0, base} + EXT_W'(SPAN);
    hit   = (addr >= base) && ({1'b0, addr} < limit);
  end
endmodule

// File: rtl/bank_xlat_ctrl.sv
module bank_xlat_ctrl
  import bank_xlat_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          INIT_W   = 8,
  parameter logic [7:0]  INIT_RST = 8'h01,
  parameter int          IO_SPAN  = 64,
  parameter int          RAM_SPAN = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [ADDR_W-1:0] winStart,
  input  logic [ADDR_W-1:0] winEnd,
  input  logic              initWrEn,
  input  logic [INIT_W-1:0] initWrData,
  output xlatStrobes_t      strobes
);
  localparam int NIB_W     = INIT_W / 2;
  localparam int IO_SHIFT  = ADDR_W - NIB_W;
  localparam int RAM_SHIFT = ADDR_W - 2 * NIB_W;

  logic [INIT_W-1:0] initReg;
  logic [ADDR_W-1:0] ioBase, ramBase;
  logic              ioMatch, ramMatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        initReg <= INIT_W'(INIT_RST);
    else if (initWrEn) initReg <= initWrData;
  end

  always_comb begin
    ioBase  = ADDR_W'(initReg[NIB_W-1:0]) << IO_SHIFT;
    ramBase = ADDR_W'(initReg[INIT_W-1:NIB_W]) << RAM_SHIFT;
  end

  bank_region_match #(.ADDR_W(ADDR_W), .SPAN(IO_SPAN)) ioMatchU (
    .addr(cpuAddr), .base(ioBase), .hit(ioMatch));
  bank_region_match #(.ADDR_W(ADDR_W), .SPAN(RAM_SPAN)) ramMatchU (
    .addr(cpuAddr), .base(ramBase), .hit(ramMatch));

  always_comb begin
    strobes.winHit = (cpuAddr >= winStart) && (cpuAddr < winEnd);
    strobes.ioHit  = ioMatch;
    strobes.ramHit = ramMatch && !ioMatch;
  end

  // R5
  init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && initWrEn) |=> initReg == $past(initWrData));
  // R5
  init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !initWrEn) |=> $stable(initReg));
  // R6
  io_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.ioHit |-> ((cpuAddr >> IO_SHIFT) == ADDR_W'(initReg[NIB_W-1:0])));
  // R7
  ram_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.ramHit |-> ((cpuAddr >> RAM_SHIFT) == ADDR_W'(initReg[INIT_W-1:NIB_W])));
endmodule

// File: rtl/bank_xlat_dp.sv
module bank_xlat_dp
  import bank_xlat_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int PAGE_W  = 16,
  parameter int SHIFT_W = 5,
  parameter int VADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  xlatStrobes_t       strobes,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic [ADDR_W-1:0]  winStart,
  input  logic [PAGE_W-1:0]  pageReg,
  input  logic [SHIFT_W-1:0] pageShift,
  input  logic [VADDR_W-1:0] virtBase,
  output logic [VADDR_W-1:0] xlatAddr
);
  logic [ADDR_W-1:0]  winOffset;
  logic [VADDR_W-1:0] pageScaled;
  logic [VADDR_W-1:0] relocAddr;

  always_comb begin
    winOffset  = cpuAddr - winStart;
    pageScaled = VADDR_W'(pageReg) << pageShift;
    relocAddr  = VADDR_W'(winOffset) + pageScaled + virtBase;
    xlatAddr   = strobes.winHit ? relocAddr : VADDR_W'(cpuAddr);
  end

  // R8
  region_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.ioHit, strobes.ramHit}));
  // R3
  pass_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.winHit |-> (xlatAddr >> ADDR_W) == '0);
  // R2
  base_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.winHit && pageReg == '0 && virtBase == '0)
      |-> xlatAddr == VADDR_W'(cpuAddr - winStart));
endmodule

// File: rtl/bank_xlat.sv
module bank_xlat
  import bank_xlat_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int PAGE_W  = 16,
  parameter int SHIFT_W = 5,
  parameter int VADDR_W = 32,
  parameter int INIT_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic [PAGE_W-1:0]  pageReg,
  input  logic [ADDR_W-1:0]  winStart,
  input  logic [ADDR_W-1:0]  winEnd,
  input  logic [SHIFT_W-1:0] pageShift,
  input  logic [VADDR_W-1:0] virtBase,
  input  logic               initWrEn,
  input  logic [INIT_W-1:0]  initWrData,
  output logic [VADDR_W-1:0] xlatAddr,
  output logic               winHit,
  output logic               ioHit,
  output logic               ramHit
);
  xlatStrobes_t strobes;

  bank_xlat_ctrl #(.ADDR_W(ADDR_W), .INIT_W(INIT_W)) ctrlU (
    .clk(clk), .rst_n(rst_n), .cpuAddr(cpuAddr), .winStart(winStart),
    .winEnd(winEnd), .initWrEn(initWrEn), .initWrData(initWrData),
    .strobes(strobes));

  bank_xlat_dp #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SHIFT_W(SHIFT_W),
                 .VADDR_W(VADDR_W)) dpU (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .cpuAddr(cpuAddr),
    .winStart(winStart), .pageReg(pageReg), .pageShift(pageShift),
    .virtBase(virtBase), .xlatAddr(xlatAddr));

  assign winHit = strobes.winHit;
  assign ioHit  = strobes.ioHit;
  assign ramHit = strobes.ramHit;

  // R1
  win_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    winHit |-> (winStart < winEnd));
endmodule

// File: tb/bank_xlat_test.sv
`timescale 1ns/100ps
module bank_xlat_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpuAddr, pageReg, winStart, winEnd;
  logic [4:0]  pageShift;
  logic [31:0] virtBase;
  logic        initWrEn;
  logic [7:0]  initWrData;
  logic [31:0] xlatAddr;
  logic        winHit, ioHit, ramHit;

  int checks = 0;
  int fails  = 0;
  logic [7:0] modelInit;

  always #2.5 clk = ~clk;

  bank_xlat uut (
    .clk(clk), .rst_n(rst_n), .cpuAddr(cpuAddr), .pageReg(pageReg),
    .winStart(winStart), .winEnd(winEnd), .pageShift(pageShift),
    .virtBase(virtBase), .initWrEn(initWrEn), .initWrData(initWrData),
    .xlatAddr(xlatAddr), .winHit(winHit), .ioHit(ioHit), .ramHit(ramHit));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h act=%h exp=%h", tag, cpuAddr, act, exp);
    end
  endtask

  task automatic probe(input int a);
    int base, rb;
    logic inWin, expIo, expRam;
    logic [31:0] expX;
    cpuAddr = a[15:0];
    #1;
    inWin = (a >= int'(winStart)) && (a < int'(winEnd));
    if (inWin)
      expX = 32'(a - int'(winStart)) + (32'(pageReg) << pageShift) + virtBase;
    else
      expX = 32'(a);
    base   = int'(modelInit[3:0]) * 4096;
    rb     = int'(modelInit[7:4]) * 256;
    expIo  = (a >= base) && (a < base + 64);
    expRam = (a >= rb) && (a < rb + 256) && !expIo;
    chk("R1 winHit", {31'b0, winHit}, {31'b0, inWin});
    chk(inWin ? "R2 reloc" : "R3 pass", xlatAddr, expX);
    chk("R6 ioHit", {31'b0, ioHit}, {31'b0, expIo});
    chk("R7 ramHit", {31'b0, ramHit}, {31'b0, expRam});
    chk("R8 excl", {31'b0, ioHit & ramHit}, 32'd0);
  endtask

  task automatic setWin(input int s, input int e, input int p, input int sh, input logic [31:0] vb);
    winStart = s[15:0]; winEnd = e[15:0]; pageReg = p[15:0];
    pageShift = sh[4:0]; virtBase = vb;
  endtask

  task automatic sweepWin();
    for (int a = 0; a < 65536; a += 61) probe(a);
    probe(0); probe(65535);
    probe(int'(winStart)); probe(int'(winEnd));
    probe((int'(winStart) + 65535) % 65536); probe((int'(winEnd) + 65535) % 65536);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; initWrEn = 1'b0; initWrData = 8'h00; cpuAddr = 16'h0;
    setWin(16'h4000, 16'h4100, 3, 14, 32'h0001_0000);
    modelInit = 8'h01;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R4: reset value 0x01 -> peripheral at 0x1000, RAM at 0x0000
    probe(16'h1000); chk("R4 io at 0x1000", {31'b0, ioHit}, 32'd1);
    probe(16'h0000); chk("R4 ram at 0x0000", {31'b0, ramHit}, 32'd1);
    probe(16'h00FF); chk("R4 ram top", {31'b0, ramHit}, 32'd1);
    probe(16'h1040); chk("R4 io end", {31'b0, ioHit}, 32'd0);

    // R1 R2 R3: window configurations
    @(negedge clk); setWin(16'h4000, 16'h4100, 3, 14, 32'h0001_0000); sweepWin();
    @(negedge clk); setWin(16'h8000, 16'h8000, 7, 4, 32'h1234_5678); sweepWin();
    @(negedge clk); setWin(16'hC000, 16'hFFFF, 1, 31, 32'h8000_1000); sweepWin();
    @(negedge clk); setWin(16'h0000, 16'h0001, 16'hFFFF, 16, 32'hFFFF_FFFF); sweepWin();
    @(negedge clk); setWin(16'h0F80, 16'h1080, 16'h00A5, 8, 32'h0); sweepWin();

    // R5 R6 R7 R8: every setup value, with same-cycle write/lookup
    @(negedge clk); setWin(16'h0F00, 16'h2000, 16'h0002, 12, 32'h0000_4000);
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      initWrEn = 1'b1; initWrData = v[7:0];
      probe(int'(v[3:0]) * 4096);       // R5: old value still decodes
      probe(int'(modelInit[3:0]) * 4096);
      @(negedge clk);
      initWrEn = 1'b0;
      modelInit = v[7:0];
      probe(int'(v[3:0]) * 4096);       // R5: new value now decodes
      chk("R5 new io base", {31'b0, ioHit}, 32'd1);
      for (int a = 0; a < 65536; a += 64) probe(a + (v % 64));
      probe(int'(v[3:0]) * 4096 + 63); probe(int'(v[3:0]) * 4096 + 64);
      probe(int'(v[7:4]) * 256 + 255); probe(int'(v[7:4]) * 256 + 256);
      probe((int'(v[3:0]) * 4096 + 65535) % 65536);
    end

    // R5: no write keeps the value
    @(negedge clk); initWrData = 8'h00;
    repeat (3) @(negedge clk);
    probe(16'hF000); chk("R5 hold", {31'b0, ioHit}, 32'd1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule